// File: doc/BRIEF.md
# Error-Tagged Serial Receive Buffer

This block is the receive-side storage for one serial channel. A character deserialiser, outside this block, presents each received byte on a one-cycle strobe together with three line-condition flags: parity error, framing error and break. The block queues up to 512 such entries in arrival order. Each entry keeps its own error tags, so software learns which byte was damaged and not only that some byte was.

Software sees two 16-bit values. The first is a data word that holds the oldest entry with its tags; a read strobe removes that entry. The second is an occupancy count. A one-bit data-available status mirrors a nonzero count. An interrupt request compares the count with one of three thresholds selected by a 2-bit code and is gated by an enable. A flush input keeps the buffer empty for as long as it stays high.

When a byte arrives while all entries are in use, the byte is discarded and the newest stored entry is marked with the overrun tag. The reader therefore sees the loss at the exact place in the stream where it happened.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset the occupancy is 0, data-available is low, the data word reads 0 and the interrupt request is low.
- R2: The data word shows the oldest entry: bits 7:0 are the character, bit 8 is the parity tag, bit 9 is the overrun tag, bit 10 is the framing tag, bit 11 is the break tag and bits 15:12 are 0. Entries leave in the order they arrived.
- R3: Each accepted write raises the occupancy by one and each accepted pop lowers it by one. A write and a pop accepted in the same cycle leave it unchanged. The occupancy never exceeds DEPTH.
- R4: A write that arrives while the buffer is full, with no pop in that cycle, is discarded and the occupancy stays at DEPTH. The overrun tag (bit 9) is then set on the most recently stored entry. A write and a pop in the same cycle while the buffer is full are both accepted, and no tag is set.
- R5: A pop while the buffer is empty sees a data word of 0 and leaves the occupancy at 0.
- R6: Data-available is high exactly when the occupancy is nonzero.
- R7: The trigger code selects threshold THR_ONE (code 1), THR_MID (code 2) or THR_HIGH (code 3). The interrupt request is high when the enable is set and the occupancy is at or above the selected threshold.
- R8: With trigger code 0, or with the enable low, the interrupt request stays low at every occupancy.
- R9: While flush is high the occupancy is 0 and writes and pops have no effect. After flush falls, writes are stored again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | One-cycle strobe: a character has been received |
| wr_char | input | 8 | Received character |
| wr_parity_err | input | 1 | Parity error flag for this character |
| wr_framing_err | input | 1 | Framing error flag for this character |
| wr_break | input | 1 | Break condition flag for this character |
| rd_pop | input | 1 | Read strobe: removes the oldest entry |
| rd_word | output | 16 | Oldest entry with its error tags, or 0 when empty |
| occupancy | output | 16 | Number of entries held |
| rx_avail | output | 1 | Data-available status |
| trig_sel | input | 2 | Interrupt threshold code (0 = off) |
| rx_irq_en | input | 1 | Receive interrupt enable |
| flush | input | 1 | Holds the buffer empty while high |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with DEPTH = 8 and thresholds of 1, 4 and 6. With these values the full, overrun, wrap-around and every threshold crossing can be reached in a few dozen cycles. At every occupancy from 0 to 8, all four trigger codes are swept with the enable both low and high, and each interrupt level is compared with a value computed arithmetically. A scoreboard queue predicts every data word, including the overrun tag placed on the last stored entry, through fill, overflow, concurrent push and pop at the full and middle levels, empty reads and flush.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int CHAR_W   = 8;
   localparam int WORD_W   = 16;
   localparam int BIT_PAR  = 8;
   localparam int BIT_OVR  = 9;
   localparam int BIT_FRM  = 10;
   localparam int BIT_BRK  = 11;

   typedef enum logic [1:0] {
      TRIG_OFF  = 2'd0,
      TRIG_ONE  = 2'd1,
      TRIG_MID  = 2'd2,
      TRIG_HIGH = 2'd3
   } trig_e;

   // stored entry: overrun tag lives in a separate flop vector
   typedef struct packed {
      logic                brk;
      logic                frm;
      logic                par;
      logic [CHAR_W-1:0]   ch;
   } entry_t;

   function automatic logic [WORD_W-1:0] to_word(entry_t e, logic ovr);
      logic [WORD_W-1:0] w;
      w = '0;
      w[CHAR_W-1:0] = e.ch;
      w[BIT_PAR]    = e.par;
      w[BIT_OVR]    = ovr;
      w[BIT_FRM]    = e.frm;
      w[BIT_BRK]    = e.brk;
      return w;
   endfunction
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
   parameter int DEPTH = 512,
   parameter int CNT_W = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_valid,
   input  logic             rd_pop,
   output logic             push,
   output logic             ovr_hit,
   output logic [PTR_W-1:0] wptr,
   output logic [PTR_W-1:0] rptr,
   output logic [PTR_W-1:0] newest,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic full, empty, pop_ok;

   assign full    = (count == FULL_CNT);
   assign empty   = (count == '0);
   assign pop_ok  = rd_pop && !empty && !flush;
   assign push    = wr_valid && !flush && (!full || pop_ok);
   assign ovr_hit = wr_valid && !flush && full && !pop_ok;
   assign newest  = wptr - PTR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push)   wptr <= wptr + PTR_W'(1);
         if (pop_ok) rptr <= rptr + PTR_W'(1);
         if (push && !pop_ok)      count <= count + CNT_W'(1);
         else if (pop_ok && !push) count <= count - CNT_W'(1);
      end
   end
endmodule

// File: rtl/rxf_store.sv
module rxf_store
   import rxf_pkg::*;
#(
   parameter int DEPTH = 512,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [PTR_W-1:0]  wptr,
   input  entry_t            wentry,
   input  logic              ovr_hit,
   input  logic [PTR_W-1:0]  newest,
   input  logic [PTR_W-1:0]  rptr,
   output logic [WORD_W-1:0] head_word
);
   entry_t           mem [DEPTH];
   logic [DEPTH-1:0] ovr_tag;

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= wentry;
   end

   // one overrun flop per slot: cleared when the slot is written, set when
   // a byte is dropped while this slot holds the newest entry
   for (genvar g = 0; g < DEPTH; g++) begin : g_ovr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ovr_tag[g] <= 1'b0;
         else if (push && wptr == PTR_W'(g))
            ovr_tag[g] <= 1'b0;
         else if (ovr_hit && newest == PTR_W'(g))
            ovr_tag[g] <= 1'b1;
      end
   end

   assign head_word = to_word(mem[rptr], ovr_tag[rptr]);
endmodule

// File: rtl/rxf_irq.sv
module rxf_irq
   import rxf_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int THR_ONE  = 1,
   parameter int THR_MID  = 256,
   parameter int THR_HIGH = 448
) (
   input  logic [CNT_W-1:0] count,
   input  logic [1:0]       trig_sel,
   input  logic             irq_en,
   output logic             irq
);
   localparam logic [CNT_W-1:0] T1 = CNT_W'(THR_ONE);
   localparam logic [CNT_W-1:0] T2 = CNT_W'(THR_MID);
   localparam logic [CNT_W-1:0] T3 = CNT_W'(THR_HIGH);

   logic [CNT_W-1:0] thr;
   logic             armed;

   always_comb begin
      armed = 1'b1;
      thr   = T1;
      unique case (trig_e'(trig_sel))
         TRIG_OFF:  armed = 1'b0;
         TRIG_ONE:  thr   = T1;
         TRIG_MID:  thr   = T2;
         TRIG_HIGH: thr   = T3;
      endcase
   end

   assign irq = irq_en && armed && (count >= thr);
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
   import rxf_pkg::*;
#(
   parameter int DEPTH    = 512,
   parameter int CNT_W    = 16,
   parameter int THR_ONE  = 1,
   parameter int THR_MID  = 256,
   parameter int THR_HIGH = 448,
   localparam int PTR_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [7:0]        wr_char,
   input  logic              wr_parity_err,
   input  logic              wr_framing_err,
   input  logic              wr_break,
   input  logic              rd_pop,
   output logic [15:0]       rd_word,
   output logic [CNT_W-1:0]  occupancy,
   output logic              rx_avail,
   input  logic [1:0]        trig_sel,
   input  logic              rx_irq_en,
   input  logic              flush,
   output logic              rx_irq
);
   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DEPTH >= (1 << CNT_W)) begin : g_bad_cnt
      $error("CNT_W too narrow for DEPTH");
   end
   if (THR_ONE < 1 || THR_ONE > DEPTH || THR_MID > DEPTH || THR_HIGH > DEPTH) begin : g_bad_thr
      $error("thresholds must lie within 1..DEPTH");
   end

   logic             push, ovr_hit;
   logic [PTR_W-1:0] wptr, rptr, newest;
   logic [15:0]      head_word;
   entry_t           wentry;

   assign wentry = '{brk: wr_break, frm: wr_framing_err, par: wr_parity_err, ch: wr_char};

   rxf_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid),
      .rd_pop(rd_pop), .push(push), .ovr_hit(ovr_hit), .wptr(wptr),
      .rptr(rptr), .newest(newest), .count(occupancy)
   );

   rxf_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .push(push), .wptr(wptr), .wentry(wentry),
      .ovr_hit(ovr_hit), .newest(newest), .rptr(rptr), .head_word(head_word)
   );

   rxf_irq #(.CNT_W(CNT_W), .THR_ONE(THR_ONE), .THR_MID(THR_MID),
             .THR_HIGH(THR_HIGH)) u_irq (
      .count(occupancy), .trig_sel(trig_sel), .irq_en(rx_irq_en), .irq(rx_irq)
   );

   assign rx_avail = (occupancy != '0);
   assign rd_word  = rx_avail ? head_word : '0;
endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
   parameter int DEPTH = 512,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_valid,
   input logic             rd_pop,
   input logic             flush,
   input logic [1:0]       trig_sel,
   input logic             rx_irq_en,
   input logic             rx_irq,
   input logic [15:0]      rd_word,
   input logic [CNT_W-1:0] occupancy
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= FULL_CNT);

   a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(flush) |-> (occupancy == $past(occupancy) ||
                         occupancy == $past(occupancy) + CNT_W'(1) ||
                         occupancy == $past(occupancy) - CNT_W'(1)));

   a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy == FULL_CNT && wr_valid && !rd_pop && !flush) |=> occupancy == FULL_CNT);

   a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy == '0 |-> rd_word == 16'h0);

   a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy == '0 && rd_pop && !wr_valid) |=> occupancy == '0);

   a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_sel == 2'd0 || !rx_irq_en) |-> !rx_irq);

   a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> occupancy == '0);
endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_pop(rd_pop),
   .flush(flush), .trig_sel(trig_sel), .rx_irq_en(rx_irq_en),
   .rx_irq(rx_irq), .rd_word(rd_word), .occupancy(occupancy)
);

// File: tb/rx_tag_fifo_bench.sv
module rx_tag_fifo_bench;
   localparam int DEPTH = 8;
   localparam int CNT_W = 16;
   localparam int T1 = 1;
   localparam int T2 = 4;
   localparam int T3 = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_valid = 1'b0;
   logic [7:0]       wr_char = '0;
   logic             wr_parity_err = 1'b0;
   logic             wr_framing_err = 1'b0;
   logic             wr_break = 1'b0;
   logic             rd_pop = 1'b0;
   logic [15:0]      rd_word;
   logic [CNT_W-1:0] occupancy;
   logic             rx_avail;
   logic [1:0]       trig_sel = 2'd0;
   logic             rx_irq_en = 1'b0;
   logic             flush = 1'b0;
   logic             rx_irq;

   int checks = 0;
   int failures = 0;
   logic [15:0] model[$];

   always #10 clk = ~clk;

   rx_tag_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_ONE(T1), .THR_MID(T2),
                 .THR_HIGH(T3)) u_rx_tag_fifo (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_char(wr_char),
      .wr_parity_err(wr_parity_err), .wr_framing_err(wr_framing_err),
      .wr_break(wr_break), .rd_pop(rd_pop), .rd_word(rd_word),
      .occupancy(occupancy), .rx_avail(rx_avail), .trig_sel(trig_sel),
      .rx_irq_en(rx_irq_en), .flush(flush), .rx_irq(rx_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit exp_irq(int cnt, int sel, bit en);
      int thr;
      thr = (sel == 1) ? T1 : (sel == 2) ? T2 : T3;
      return en && sel != 0 && cnt >= thr;
   endfunction

   // one clock: apply inputs, check head if popping, update model, check count
   task automatic cyc(input bit wv, input logic [7:0] c, input bit p, input bit f,
                      input bit b, input bit pop);
      int  n;
      bit  popok;
      n = model.size();
      wr_valid = wv; wr_char = c; wr_parity_err = p; wr_framing_err = f;
      wr_break = b; rd_pop = pop;
      #1;
      if (pop) begin
         if (n == 0) chk("R5 empty read word", rd_word, 16'h0);
         else        chk("R2 head word", rd_word, model[0]);
      end
      popok = pop && n > 0 && !flush;
      if (popok) void'(model.pop_front());
      if (wv && !flush) begin
         if (n < DEPTH || popok) model.push_back({4'b0, b, f, 1'b0, p, c});
         else model[model.size()-1][9] = 1'b1;
      end
      if (flush) model.delete();
      @(posedge clk);
      #1;
      wr_valid = 1'b0; rd_pop = 1'b0;
      chk("R3 occupancy", occupancy, model.size());
      chk("R6 avail", rx_avail, model.size() != 0);
   endtask

   task automatic irq_sweep();
      for (int s = 0; s < 4; s++) begin
         for (int e = 0; e < 2; e++) begin
            trig_sel = s[1:0]; rx_irq_en = e[0];
            #1;
            if (s == 0 || e == 0) chk("R8 irq gated", rx_irq, 1'b0);
            else chk("R7 irq threshold", rx_irq, exp_irq(model.size(), s, e[0]));
         end
      end
      trig_sel = 2'd0; rx_irq_en = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset occupancy", occupancy, 0);
      chk("R1 reset avail", rx_avail, 0);
      chk("R1 reset word", rd_word, 0);
      chk("R1 reset irq", rx_irq, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      irq_sweep();

      // fill to full with varied tags; sweep irq at every level (R3, R7)
      for (int i = 0; i < DEPTH; i++) begin
         cyc(1'b1, 8'(8'h30 + i * 7), i[0], i[1], i[2], 1'b0);
         irq_sweep();
      end
      // R4: two writes while full are dropped, newest tagged overrun
      cyc(1'b1, 8'hEE, 1'b1, 1'b1, 1'b1, 1'b0);
      cyc(1'b1, 8'hDD, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R4 full hold", occupancy, DEPTH);
      // R4: write+pop while full is accepted
      cyc(1'b1, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b1);
      // drain everything, words checked against model (R2, R4 tag)
      for (int i = 0; i < DEPTH; i++) begin
         cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1);
         irq_sweep();
      end
      // R5: pops while empty
      cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1);
      cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R5 still empty", occupancy, 0);

      // R3: mid-level concurrent write and pop, with pointer wrap
      for (int i = 0; i < 3; i++) cyc(1'b1, 8'(8'h80 + i), 1'b0, i[0], 1'b0, 1'b0);
      for (int i = 0; i < 10; i++) cyc(1'b1, 8'(8'hC0 + i), i[1], 1'b0, i[0], 1'b1);
      chk("R3 concurrent unchanged", occupancy, 3);

      // R9: flush holds empty, writes ignored, then resumes
      for (int i = 0; i < 2; i++) cyc(1'b1, 8'(8'h11 * i), 1'b1, 1'b0, 1'b0, 1'b0);
      flush = 1'b1;
      cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R9 flushed", occupancy, 0);
      cyc(1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
      cyc(1'b1, 8'h66, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R9 writes ignored", occupancy, 0);
      chk("R9 word empty", rd_word, 0);
      flush = 1'b0;
      cyc(1'b1, 8'h77, 1'b1, 1'b1, 1'b0, 1'b0);
      chk("R9 resumed word", rd_word, 16'h0577);
      cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule